// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Controller

This block produces the interrupt and DMA request signals for a synchronous serial port that has a transmit FIFO and a receive FIFO. It watches the occupancy counts of both FIFOs, a one-cycle pulse for every received frame, and a one-cycle pulse for every read from the receive FIFO. From these it derives four interrupt conditions.

Two of the conditions are sticky events: receive overrun and receive timeout. Software clears them by writing ones to a clear register. The other two follow the FIFO levels directly. Receive is at least half full, and transmit is at least half empty. Software cannot clear these two by a write. They end when the FIFO level changes, or they can be hidden by the enable mask.

Software reaches the raw status, the mask, the masked status, the clear register and the DMA enables through a simple register bus. A write takes effect on the clock edge. A read is combinational on the selected address. The block drives one combined interrupt line and separate receive and transmit DMA request lines.

Top module: `ssp_irq_dma`

## Requirements
- R1: After reset the mask register, the DMA control register and both sticky events are 0, so `irq`, `rx_dma_req` and `tx_dma_req` are low.
- R2: Overrun event (raw status bit 0, address 0) is set on the clock edge where `rx_frame_done` is high while `rx_level` equals DEPTH. It stays set until it is cleared, and a frame arriving at any lower level leaves it unchanged.
- R3: Receive timeout event (raw status bit 1) is governed by a counter. The counter reloads on any edge with `rx_fifo_read`, with `rx_frame_done`, or with an empty receive FIFO. The event is set on the TIMEOUT-th consecutive edge without a reload, and never while the FIFO is empty.
- R4: Raw status bit 2 is 1 exactly when `rx_level` >= DEPTH/2.
- R5: Raw status bit 3 is 1 exactly when DEPTH - `tx_level` >= DEPTH/2.
- R6: The masked status (address 2) equals the raw status ANDed with the 4-bit mask (address 1, bit i enables raw bit i). `irq` is the OR of the four masked bits.
- R7: A write to the clear register (address 3) clears the overrun event for each 1 in bit 0 and the timeout event for each 1 in bit 1. A 0 in either bit leaves the event unchanged. The clear register reads as 0.
- R8: Writes to the clear register have no effect on raw status bits 2 and 3.
- R9: If an event sets in the same cycle as a write-one clear of it, the event ends up set.
- R10: DMA control (address 4) has bit 0 enabling receive and bit 1 enabling transmit requests, and it is read/write. `rx_dma_req` = bit 0 AND `rx_level` != 0. `tx_dma_req` = bit 1 AND `tx_level` != DEPTH.
- R11: Writing ones to unused bits of the mask and DMA control registers changes nothing. Unused bits and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO occupancy |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO occupancy |
| rx_frame_done | input | 1 | Pulse: a complete frame was received |
| rx_fifo_read | input | 1 | Pulse: the receive FIFO was read |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| irq | output | 1 | Combined interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with DEPTH = 8 and TIMEOUT = 5. With these values every receive and transmit level pair, 81 in all, can be swept against all 16 mask values and all 4 DMA enable settings, with the expected values computed arithmetically. The short timeout allows the set edge to be checked exactly, one cycle early and on time, along with reloads by reads and by frames. The full-FIFO overrun case, the one-below-full case and the same-cycle set/clear collision are each driven directly.

// File: rtl/ssp_irq_dma.sv
module ssp_irq_dma #(
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 32,
  parameter int AW      = 3,
  parameter int DW      = 8,
  localparam int LW     = $clog2(DEPTH + 1),
  localparam int TW     = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          rx_frame_done,
  input  logic          rx_fifo_read,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          rx_dma_req,
  output logic          tx_dma_req
);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-1:0] A_RAW = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_MSKD = AW'(2);
  localparam logic [AW-1:0] A_CLR = AW'(3);
  localparam logic [AW-1:0] A_DMA = AW'(4);

  logic          ovr_q, rt_q;
  logic [3:0]    mask_q;
  logic [1:0]    dma_q;
  logic [TW-1:0] to_cnt;
  logic [3:0]    raw, masked;

  wire rx_full  = rx_level == LW'(DEPTH);
  wire rx_empty = rx_level == '0;
  wire tx_full  = tx_level == LW'(DEPTH);
  wire rx_half  = rx_level >= LW'(HALF);
  wire tx_half  = (LW'(DEPTH) - tx_level) >= LW'(HALF);

  wire wr_mask = bus_we && bus_addr == A_MASK;
  wire wr_clr  = bus_we && bus_addr == A_CLR;
  wire wr_dma  = bus_we && bus_addr == A_DMA;
  wire clr_ovr = wr_clr && bus_wdata[0];
  wire clr_rt  = wr_clr && bus_wdata[1];
  logic unused_wbits;
  assign unused_wbits = ^bus_wdata[DW-1:4];

  wire ovr_set   = rx_frame_done && rx_full;
  wire to_reload = rx_fifo_read || rx_frame_done || rx_empty;
  wire rt_set    = !to_reload && to_cnt == TW'(TIMEOUT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)                      to_cnt <= '0;
    else if (to_reload)              to_cnt <= '0;
    else if (to_cnt != TW'(TIMEOUT)) to_cnt <= to_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      rt_q   <= 1'b0;
      mask_q <= '0;
      dma_q  <= '0;
    end else begin
      if (ovr_set)      ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;
      if (rt_set)       rt_q <= 1'b1;
      else if (clr_rt)  rt_q <= 1'b0;
      if (wr_mask)      mask_q <= bus_wdata[3:0];
      if (wr_dma)       dma_q <= bus_wdata[1:0];
    end
  end

  assign raw    = {tx_half, rx_half, rt_q, ovr_q};
  assign masked = raw & mask_q;
  assign irq    = |masked;

  assign rx_dma_req = dma_q[0] && !rx_empty;
  assign tx_dma_req = dma_q[1] && !tx_full;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RAW:   bus_rdata[3:0] = raw;
      A_MASK:  bus_rdata[3:0] = mask_q;
      A_MSKD:  bus_rdata[3:0] = masked;
      A_DMA:   bus_rdata[1:0] = dma_q;
      default: bus_rdata = '0;
    endcase
  end

  p_ovr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_done && rx_full) |=> ovr_q);
  p_ovr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(bus_we && bus_addr == A_CLR && bus_wdata[0])) |=> ovr_q);
  p_rt_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rt_q) |-> $past(rx_level) != '0);
  p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR && bus_wdata[1] && rx_fifo_read) |=> !rt_q);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_done && rx_full && bus_we && bus_addr == A_CLR) |=> ovr_q);
  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q != '0);
  p_tx_dma_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> tx_level != LW'(DEPTH));
endmodule

// File: tb/tb_ssp_irq_dma.sv
module tb_ssp_irq_dma;
  localparam int DEPTH = 8, TIMEOUT = 5, AW = 3, DW = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [LW-1:0] rx_level = '0, tx_level = '0;
  logic rx_frame_done = 0, rx_fifo_read = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq, rx_dma_req, tx_dma_req;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ssp_irq_dma #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .rx_frame_done(rx_frame_done), .rx_fifo_read(rx_fifo_read),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rx_dma_req(rx_dma_req),
    .tx_dma_req(tx_dma_req));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = DW'(d); bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(int a, output int d);
    bus_addr = AW'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    tx_level = LW'(DEPTH);
    idle(3);
    rst_n = 1;
    // R1 reset state
    rd(1, v); check("R1 mask", v, 0);
    rd(4, v); check("R1 dma", v, 0);
    rd(0, v); check("R1 sticky", v & 3, 0);
    check("R1 irq", irq, 0);
    check("R1 rx_dma_req", rx_dma_req, 0);
    check("R1 tx_dma_req", tx_dma_req, 0);

    // R2 overrun: not at DEPTH-1, set at full
    rx_level = LW'(DEPTH - 1);
    @(negedge clk); rx_frame_done = 1; @(negedge clk); rx_frame_done = 0;
    rd(0, v); check("R2 no overrun below full", v & 1, 0);
    rx_level = LW'(DEPTH);
    @(negedge clk); rx_frame_done = 1; @(negedge clk); rx_frame_done = 0;
    rd(0, v); check("R2 overrun set", v & 1, 1);
    rx_level = '0;
    idle(3);
    rd(0, v); check("R2 overrun sticky", v & 1, 1);
    // R7 writing zero leaves it, writing one clears
    wr(3, 8'hFC);
    rd(0, v); check("R7 zero write keeps overrun", v & 1, 1);
    rd(3, v); check("R7 clear reads zero", v, 0);
    wr(3, 1);
    rd(0, v); check("R7 overrun cleared", v & 1, 0);

    // R9 set wins over same-cycle clear
    rx_level = LW'(DEPTH);
    @(negedge clk);
    rx_frame_done = 1; bus_addr = 3; bus_wdata = 8'h03; bus_we = 1;
    @(negedge clk);
    rx_frame_done = 0; bus_we = 0;
    rd(0, v); check("R9 set wins", v & 1, 1);
    wr(3, 1);

    // R3 timeout: empty never sets
    rx_level = '0;
    idle(3 * TIMEOUT);
    rd(0, v); check("R3 empty no timeout", v & 2, 0);
    // exact timing after a read
    rx_level = 3;
    @(negedge clk); rx_fifo_read = 1; @(negedge clk); rx_fifo_read = 0;
    idle(TIMEOUT - 1);
    rd(0, v); check("R3 not yet at T-1", v & 2, 0);
    idle(1);
    rd(0, v); check("R3 set at T", v & 2, 2);
    wr(3, 2);
    idle(2 * TIMEOUT);
    rd(0, v); check("R3/R7 cleared stays clear", v & 2, 0);
    // reload by frame and read keeps it clear
    for (int i = 0; i < 4 * TIMEOUT; i++) begin
      @(negedge clk);
      rx_frame_done = (i % (TIMEOUT - 1) == 0);
      rx_fifo_read  = (i % (TIMEOUT - 1) == 2);
    end
    @(negedge clk); rx_frame_done = 0; rx_fifo_read = 0;
    rd(0, v); check("R3 reloads prevent timeout", v & 2, 0);
    // R7 clear with data present and reads every cycle
    rx_fifo_read = 1;

    // R4 R5 R6 R8 sweep (reads each cycle hold timeout off)
    wr(3, 3);
    for (int rl = 0; rl <= DEPTH; rl++)
      for (int tl = 0; tl <= DEPTH; tl++) begin
        int raw;
        rx_level = LW'(rl); tx_level = LW'(tl);
        raw = ((rl >= DEPTH / 2) ? 4 : 0) | ((DEPTH - tl >= DEPTH / 2) ? 8 : 0);
        rd(0, v); check("R4/R5 raw", v, raw);
        for (int m = 0; m < 16; m++) begin
          wr(1, m);
          rd(2, v); check("R6 masked", v, raw & m);
          check("R6 irq", irq, ((raw & m) != 0) ? 1 : 0);
        end
        wr(3, 8'hFF);
        rd(0, v); check("R8 clear leaves levels", v, raw);
      end

    // R10 DMA sweep
    for (int d = 0; d < 4; d++) begin
      wr(4, d);
      rd(4, v); check("R10 dma readback", v, d);
      for (int rl = 0; rl <= DEPTH; rl++)
        for (int tl = 0; tl <= DEPTH; tl++) begin
          rx_level = LW'(rl); tx_level = LW'(tl);
          #1;
          check("R10 rx_dma_req", rx_dma_req, ((d & 1) && rl != 0) ? 1 : 0);
          check("R10 tx_dma_req", tx_dma_req, ((d & 2) && tl != DEPTH) ? 1 : 0);
        end
    end

    // R11 reserved bits and unmapped addresses
    rx_level = 3; tx_level = LW'(DEPTH);
    wr(1, 8'hF0);
    rd(1, v); check("R11 mask reserved", v, 0);
    check("R11 irq unaffected", irq, 0);
    wr(4, 8'hFC);
    rd(4, v); check("R11 dma reserved", v, 0);
    check("R11 rx_dma_req unaffected", rx_dma_req, 0);
    wr(1, 8'hFF);
    rd(1, v); check("R11 mask upper reads zero", v, 15);
    for (int a = 5; a < 8; a++) begin
      rd(a, v); check("R11 unmapped", v, 0);
    end
    rx_fifo_read = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule